// File: doc/BRIEF.md
# Multi-mode DMA channel sequencer

One DMA channel with its own bus-hold sequencing. It holds a current address and word count, plus a base copy of each used for automatic reinitialization. The channel asks a host for the bus with a hold request. Once the host grants hold, the channel acknowledges its peripheral and issues transfer strobes. Each strobe carries the address and the transfer direction. A strobe that consumes the last word raises a terminal-count pulse.

Four transfer modes set when the channel gives the bus back:

- **Single:** one transfer per grant.
- **Block:** continues to terminal count. It can be started by the peripheral or by a software request.
- **Demand:** continues while the peripheral keeps requesting.
- **Cascade:** the channel only passes a downstream controller's request upward and the grant back down.

Arbitration against other channels is reduced to one priority-override input. Data movement and host register decoding belong to the surrounding logic.

Top module: `dma_ch_seq`

## Requirements
- R1: After reset:
  - `hrq_o`, `dack_o`, `xfer_o` and `tc_o` are low.
  - `mask_o` is 1 and `tc_stat_o` is 0.
  - Current address and count are 0.
  - The mode is demand.
- R2: `cfg_mode_i` encodes the mode: 00 demand, 01 single, 10 block, 11 cascade. It is stored with the direction bit, the auto-init bit and the decrement bit on a cycle with `cfg_we_i` high.
- R3: `base_we_i` loads the base and the current address and count on the same edge. The new values appear on `cur_addr_o`/`cur_cnt_o` on the next cycle.
- R4: Each transfer is one `xfer_o` cycle, with `xfer_addr_o` equal to the current address and `xfer_to_mem_o` equal to the direction bit.
  - On the next cycle the count has dropped by one.
  - The address has moved by one: down if the decrement bit is set, up otherwise.
  - Outside a transfer, `xfer_addr_o` and `xfer_to_mem_o` are 0.
- R5: A transfer made with count 0 raises `tc_o` in the same cycle and sets `tc_stat_o` on the next one. `stat_rd_i` clears `tc_stat_o` unless a terminal count sets it in that same cycle.
- R6: At terminal count:
  - With auto-init set, address and count reload from the base values.
  - Otherwise the count wraps to all ones, the address steps as usual, `mask_o` is set, and no further request is raised.
- R7: When idle, unmasked, not in cascade mode and with `prio_hold_i` low, a request raises `hrq_o` on the next cycle. A request is `dreq_i`, or in block mode a pending software request.
  - `dack_o` is high only while hold is granted and the channel owns the bus.
  - `dack_o` falls in the same cycle as `hrq_o`.
- R8: Single mode makes one transfer and then drops `hrq_o`. It raises `hrq_o` again only after `hlda_i` has gone low and a new request is seen.
- R9: In block mode, a `sw_req_i` pulse is latched and starts the sequence. Transfers then run every granted cycle until terminal count, whatever `dreq_i` does.
- R10: In demand mode, a transfer occurs on each granted cycle with `dreq_i` high. The bus is released as soon as `dreq_i` is low or terminal count is reached.
- R11: In cascade mode:
  - `hrq_o` follows `dreq_i` and `dack_o` follows `hlda_i`.
  - No strobe is issued and the address output stays 0.
  - The channel leaves cascade service once both `dreq_i` and `hlda_i` are low.
- R12: While cascade service is active, the host-side inputs have no effect. These are the configuration, base, mask, software-request, status-read and priority inputs.
- R13: `mask_set_i` sets and `mask_clr_i` clears `mask_o`. A masked channel raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Store mode and option bits |
| cfg_mode_i | input | 2 | Transfer mode code |
| cfg_dec_i | input | 1 | Address steps downward |
| cfg_auto_i | input | 1 | Reload from base at terminal count |
| cfg_to_mem_i | input | 1 | Transfer direction bit |
| base_we_i | input | 1 | Load base and current registers |
| base_addr_i | input | ADDR_W | Start address |
| base_cnt_i | input | CNT_W | Word count minus one |
| mask_set_i | input | 1 | Set request mask |
| mask_clr_i | input | 1 | Clear request mask |
| sw_req_i | input | 1 | Software request pulse (block mode) |
| stat_rd_i | input | 1 | Status read, clears terminal-count bit |
| prio_hold_i | input | 1 | Higher-priority request pending |
| dreq_i | input | 1 | Peripheral request |
| hlda_i | input | 1 | Hold granted by host |
| hrq_o | output | 1 | Hold request to host |
| dack_o | output | 1 | Acknowledge to peripheral |
| xfer_o | output | 1 | One-cycle transfer strobe |
| xfer_addr_o | output | ADDR_W | Address of the strobed transfer |
| xfer_to_mem_o | output | 1 | Direction of the strobed transfer |
| tc_o | output | 1 | Terminal-count pulse |
| tc_stat_o | output | 1 | Terminal-count status bit |
| mask_o | output | 1 | Request mask bit |
| cur_addr_o | output | ADDR_W | Current address |
| cur_cnt_o | output | CNT_W | Current word count |

## Verification
The assertions assume the host holds `hlda_i` high for as long as the channel keeps `hrq_o` high. They also assume the mode is never rewritten while a sequence is in progress. The bench meets both conditions:
- Its host model returns `hlda_i` as a one-cycle-delayed copy of `hrq_o`.
- It rewrites the configuration only while the channel is idle with `dreq_i` low.
- It issues base writes and status reads only while idle or while cascade service is active.

The latter case is deliberate, to show that R12 ignores them.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  typedef enum logic [1:0] {
    MODE_DEMAND  = 2'b00,
    MODE_SINGLE  = 2'b01,
    MODE_BLOCK   = 2'b10,
    MODE_CASCADE = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_REL,
    ST_CASC
  } seq_state_e;
endpackage

// File: rtl/dma_ch_ctl.sv
module dma_ch_ctl
  import dma_ch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_en_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       cfg_dec_i,
  input  logic       cfg_auto_i,
  input  logic       cfg_to_mem_i,
  input  logic       mask_set_i,
  input  logic       mask_clr_i,
  input  logic       sw_req_i,
  input  logic       stat_rd_i,
  input  logic       tc_hit_i,
  input  logic       grant_i,
  output xfer_mode_e mode_o,
  output logic       dec_o,
  output logic       auto_o,
  output logic       to_mem_o,
  output logic       mask_o,
  output logic       tc_stat_o,
  output logic       sw_pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_DEMAND;
      dec_o    <= 1'b0;
      auto_o   <= 1'b0;
      to_mem_o <= 1'b0;
    end else if (host_en_i && cfg_we_i) begin
      mode_o   <= xfer_mode_e'(cfg_mode_i);
      dec_o    <= cfg_dec_i;
      auto_o   <= cfg_auto_i;
      to_mem_o <= cfg_to_mem_i;
    end
  end

  // terminal count outranks host writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o    <= 1'b1;
      tc_stat_o <= 1'b0;
      sw_pend_o <= 1'b0;
    end else begin
      if (tc_hit_i && !auto_o)            mask_o <= 1'b1;
      else if (host_en_i && mask_set_i)   mask_o <= 1'b1;
      else if (host_en_i && mask_clr_i)   mask_o <= 1'b0;

      if (tc_hit_i)                       tc_stat_o <= 1'b1;
      else if (host_en_i && stat_rd_i)    tc_stat_o <= 1'b0;

      if (host_en_i && sw_req_i && mode_o == MODE_BLOCK) sw_pend_o <= 1'b1;
      else if (grant_i)                                  sw_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic              step_i,
  input  logic              dec_i,
  input  logic              auto_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic              at_zero_o
);
  localparam logic [ADDR_W-1:0] AONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CONE = CNT_W'(1);

  logic [ADDR_W-1:0] base_addr_q;
  logic [CNT_W-1:0]  base_cnt_q;

  assign at_zero_o = (cur_cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_o  <= '0;
      cur_cnt_o   <= '0;
    end else if (load_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
      cur_addr_o  <= base_addr_i;
      cur_cnt_o   <= base_cnt_i;
    end else if (step_i) begin
      if (at_zero_o && auto_i) begin
        cur_addr_o <= base_addr_q;
        cur_cnt_o  <= base_cnt_q;
      end else begin
        cur_addr_o <= dec_i ? cur_addr_o - AONE : cur_addr_o + AONE;
        cur_cnt_o  <= cur_cnt_o - CONE;
      end
    end
  end
endmodule

// File: rtl/dma_ch_fsm.sv
module dma_ch_fsm
  import dma_ch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  xfer_mode_e mode_i,
  input  logic       mask_i,
  input  logic       prio_hold_i,
  input  logic       dreq_i,
  input  logic       hlda_i,
  input  logic       sw_pend_i,
  input  logic       at_zero_i,
  output logic       hrq_o,
  output logic       dack_o,
  output logic       fire_o,
  output logic       casc_busy_o,
  output logic       grant_o
);
  seq_state_e st_q, st_d;
  logic want;

  always_comb begin
    want        = !mask_i && !prio_hold_i &&
                  (dreq_i || (mode_i == MODE_BLOCK && sw_pend_i));
    fire_o      = (st_q == ST_XFER) && hlda_i &&
                  (mode_i != MODE_DEMAND || dreq_i);
    hrq_o       = (st_q == ST_REQ) || (st_q == ST_XFER) ||
                  (st_q == ST_CASC && dreq_i);
    dack_o      = (st_q == ST_XFER || st_q == ST_CASC) && hlda_i;
    casc_busy_o = (st_q == ST_CASC);
    grant_o     = (st_q == ST_REQ) && hlda_i;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (mode_i == MODE_CASCADE) begin
          if (dreq_i && !mask_i) st_d = ST_CASC;
        end else if (want) begin
          st_d = ST_REQ;
        end
      end
      ST_REQ:  if (hlda_i) st_d = ST_XFER;
      ST_XFER: begin
        if (mode_i == MODE_DEMAND && !dreq_i) st_d = ST_REL;
        else if (fire_o && (mode_i == MODE_SINGLE || at_zero_i)) st_d = ST_REL;
      end
      ST_REL:  if (!hlda_i) st_d = ST_IDLE;
      ST_CASC: if (!dreq_i && !hlda_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_dec_i,
  input  logic              cfg_auto_i,
  input  logic              cfg_to_mem_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              sw_req_i,
  input  logic              stat_rd_i,
  input  logic              prio_hold_i,
  input  logic              dreq_i,
  input  logic              hlda_i,
  output logic              hrq_o,
  output logic              dack_o,
  output logic              xfer_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              xfer_to_mem_o,
  output logic              tc_o,
  output logic              tc_stat_o,
  output logic              mask_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o
);
  xfer_mode_e mode;
  logic dec, auto_init, to_mem, sw_pend, at_zero;
  logic fire, casc_busy, grant, host_en;

  assign host_en       = !casc_busy;
  assign xfer_o        = fire;
  assign tc_o          = fire && at_zero;
  assign xfer_addr_o   = fire ? cur_addr_o : '0;
  assign xfer_to_mem_o = fire && to_mem;

  dma_ch_ctl u_ctl (
    .clk_i, .rst_ni,
    .host_en_i(host_en),
    .cfg_we_i, .cfg_mode_i, .cfg_dec_i, .cfg_auto_i, .cfg_to_mem_i,
    .mask_set_i, .mask_clr_i, .sw_req_i, .stat_rd_i,
    .tc_hit_i(tc_o),
    .grant_i(grant),
    .mode_o(mode), .dec_o(dec), .auto_o(auto_init), .to_mem_o(to_mem),
    .mask_o, .tc_stat_o, .sw_pend_o(sw_pend)
  );

  dma_ch_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .load_i(base_we_i && host_en),
    .base_addr_i, .base_cnt_i,
    .step_i(fire),
    .dec_i(dec), .auto_i(auto_init),
    .cur_addr_o, .cur_cnt_o,
    .at_zero_o(at_zero)
  );

  dma_ch_fsm u_fsm (
    .clk_i, .rst_ni,
    .mode_i(mode), .mask_i(mask_o), .prio_hold_i, .dreq_i, .hlda_i,
    .sw_pend_i(sw_pend), .at_zero_i(at_zero),
    .hrq_o, .dack_o, .fire_o(fire),
    .casc_busy_o(casc_busy), .grant_o(grant)
  );
endmodule

// File: rtl/dma_ch_seq_chk.sv
module dma_ch_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hrq_o,
  input logic              dack_o,
  input logic              hlda_i,
  input logic              xfer_o,
  input logic              tc_o,
  input logic              tc_stat_o,
  input logic              mask_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic [CNT_W-1:0]  cur_cnt_o,
  input logic              base_we_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic              casc_busy,
  input logic [1:0]        mode,
  input logic              auto_init
);
  a_r7_dack_needs_hlda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> hlda_i);
  a_r7_dack_drops_with_hrq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != 2'b11 && $fell(hrq_o)) |-> !dack_o);
  a_r5_tc_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> xfer_o);
  a_r5_tc_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> tc_stat_o);
  a_r6_mask_on_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !auto_init) |=> mask_o);
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !tc_o && !base_we_i) |=> cur_cnt_o == $past(cur_cnt_o) - CNT_W'(1));
  a_r8_single_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && mode == 2'b01) |=> !hrq_o);
  a_r11_casc_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_busy |-> !xfer_o);
  a_r12_casc_base_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_busy && base_we_i) |=> $stable(cur_addr_o));
  a_r3_base_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_i && !casc_busy) |=> cur_addr_o == $past(base_addr_i));
  a_r13_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != 2'b11 && $rose(hrq_o)) |-> !$past(mask_o));
endmodule

bind dma_ch_seq dma_ch_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hrq_o(hrq_o), .dack_o(dack_o),
  .hlda_i(hlda_i), .xfer_o(xfer_o), .tc_o(tc_o), .tc_stat_o(tc_stat_o),
  .mask_o(mask_o), .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o),
  .base_we_i(base_we_i), .base_addr_i(base_addr_i), .casc_busy(casc_busy),
  .mode(mode), .auto_init(auto_init)
);

// File: tb/tb_dma_ch_seq.sv
module tb_dma_ch_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_we = 0, cfg_dec = 0, cfg_auto = 0, cfg_to_mem = 0;
  logic [1:0] cfg_mode = 0;
  logic base_we = 0;
  logic [15:0] base_addr = 0, base_cnt = 0;
  logic mask_set = 0, mask_clr = 0, sw_req = 0, stat_rd = 0, prio = 0;
  logic dreq = 0, hlda = 0;
  logic hrq, dack, xfer, to_mem, tc, tcs, mask;
  logic [15:0] xaddr, caddr, ccnt;

  dma_ch_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_dec_i(cfg_dec), .cfg_auto_i(cfg_auto), .cfg_to_mem_i(cfg_to_mem),
    .base_we_i(base_we), .base_addr_i(base_addr), .base_cnt_i(base_cnt),
    .mask_set_i(mask_set), .mask_clr_i(mask_clr), .sw_req_i(sw_req),
    .stat_rd_i(stat_rd), .prio_hold_i(prio), .dreq_i(dreq), .hlda_i(hlda),
    .hrq_o(hrq), .dack_o(dack), .xfer_o(xfer), .xfer_addr_o(xaddr),
    .xfer_to_mem_o(to_mem), .tc_o(tc), .tc_stat_o(tcs), .mask_o(mask),
    .cur_addr_o(caddr), .cur_cnt_o(ccnt)
  );

  int checks = 0, fails = 0, xfers = 0;
  string tag = "R1";
  // reference model: 0 idle, 1 requesting, 2 owning, 3 releasing, 4 cascade
  int ph = 0;
  int m_addr = 0, m_cnt = 0, m_baddr = 0, m_bcnt = 0;
  int m_mode = 0, m_dec = 0, m_auto = 0, m_tom = 0;
  int m_mask = 1, m_tcs = 0, m_swq = 0;
  logic seen_hrq = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s act=%h exp=%h", req, tag, what, act, exp);
    end
  endtask

  task automatic step();
    int e_hrq, e_dack, fire, e_tc, nph, host;
    #5;
    e_hrq  = (ph == 1 || ph == 2 || (ph == 4 && dreq)) ? 1 : 0;
    e_dack = ((ph == 2 || ph == 4) && hlda) ? 1 : 0;
    fire   = (ph == 2 && hlda && (m_mode != 0 || dreq)) ? 1 : 0;
    e_tc   = (fire == 1 && m_cnt == 0) ? 1 : 0;
    chk("R7", "hrq", int'(hrq), e_hrq);
    chk("R7", "dack", int'(dack), e_dack);
    chk("R4", "xfer", int'(xfer), fire);
    chk("R4", "xfer_addr", int'(xaddr), fire ? m_addr : 0);
    chk("R4", "xfer_to_mem", int'(to_mem), fire ? m_tom : 0);
    chk("R5", "tc", int'(tc), e_tc);
    chk("R5", "tc_stat", int'(tcs), m_tcs);
    chk("R6", "mask", int'(mask), m_mask);
    chk("R4", "cur_addr", int'(caddr), m_addr);
    chk("R4", "cur_cnt", int'(ccnt), m_cnt);
    if (xfer) xfers++;
    seen_hrq = hrq;

    host = (ph != 4) ? 1 : 0;
    nph = ph;
    case (ph)
      0: if (m_mode == 3) begin
           if (dreq && m_mask == 0) nph = 4;
         end else if (m_mask == 0 && !prio && (dreq || (m_mode == 2 && m_swq == 1))) nph = 1;
      1: if (hlda) nph = 2;
      2: if (m_mode == 0 && !dreq) nph = 3;
         else if (fire == 1 && (m_mode == 1 || e_tc == 1)) nph = 3;
      3: if (!hlda) nph = 0;
      4: if (!dreq && !hlda) nph = 0;
      default: nph = 0;
    endcase

    if (host == 1 && base_we) begin
      m_baddr = base_addr; m_bcnt = base_cnt; m_addr = base_addr; m_cnt = base_cnt;
    end else if (fire == 1) begin
      if (e_tc == 1 && m_auto == 1) begin
        m_addr = m_baddr; m_cnt = m_bcnt;
      end else begin
        m_addr = (m_dec == 1 ? m_addr - 1 : m_addr + 1) & 16'hFFFF;
        m_cnt  = (m_cnt - 1) & 16'hFFFF;
      end
    end
    if (e_tc == 1 && m_auto == 0)      m_mask = 1;
    else if (host == 1 && mask_set)    m_mask = 1;
    else if (host == 1 && mask_clr)    m_mask = 0;
    if (e_tc == 1)                     m_tcs = 1;
    else if (host == 1 && stat_rd)     m_tcs = 0;
    if (host == 1 && sw_req && m_mode == 2) m_swq = 1;
    else if (ph == 1 && hlda)               m_swq = 0;
    if (host == 1 && cfg_we) begin
      m_mode = cfg_mode; m_dec = cfg_dec; m_auto = cfg_auto; m_tom = cfg_to_mem;
    end
    ph = nph;

    @(negedge clk);
    hlda = seen_hrq;
    cfg_we = 0; base_we = 0; mask_set = 0; mask_clr = 0; sw_req = 0; stat_rd = 0;
  endtask

  task automatic setup(input logic [1:0] md, input logic dc, input logic au,
                       input logic tm, input logic [15:0] a, input logic [15:0] c);
    cfg_we = 1; cfg_mode = md; cfg_dec = dc; cfg_auto = au; cfg_to_mem = tm;
    base_we = 1; base_addr = a; base_cnt = c; mask_clr = 1;
    step();
  endtask

  initial begin
    logic [15:0] a0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "mask reset", int'(mask), 1);
    chk("R1", "hrq reset", int'(hrq), 0);
    step();

    tag = "R8";
    setup(2'b01, 0, 0, 1, 16'h1000, 16'd2);
    chk("R3", "base load addr", int'(caddr), 16'h1000);
    chk("R3", "base load cnt", int'(ccnt), 2);
    xfers = 0; dreq = 1;
    repeat (20) step();
    chk("R8", "single transfer count", xfers, 3);
    chk("R6", "mask after tc", int'(mask), 1);
    chk("R6", "count wrap", int'(ccnt), 16'hFFFF);
    chk("R5", "status set", int'(tcs), 1);
    stat_rd = 1; step();
    chk("R5", "status cleared", int'(tcs), 0);
    dreq = 0; repeat (3) step();

    tag = "R9";
    setup(2'b10, 1, 1, 0, 16'h2000, 16'd3);
    xfers = 0; sw_req = 1; step();
    repeat (15) step();
    chk("R9", "R2 block transfer count", xfers, 4);
    chk("R6", "auto reload addr", int'(caddr), 16'h2000);
    chk("R6", "auto reload cnt", int'(ccnt), 3);
    chk("R6", "mask stays clear", int'(mask), 0);

    tag = "R10";
    setup(2'b00, 0, 0, 1, 16'h3000, 16'd10);
    prio = 1; dreq = 1;
    repeat (4) step();
    chk("R7", "prio hold blocks", int'(hrq), 0);
    prio = 0; repeat (6) step();
    dreq = 0; repeat (5) step();
    chk("R10", "release on dreq low", int'(hrq), 0);
    dreq = 1; repeat (6) step();
    dreq = 0; repeat (5) step();

    tag = "R11";
    cfg_we = 1; cfg_mode = 2'b11; cfg_dec = 0; cfg_auto = 0; mask_clr = 1;
    step();
    a0 = caddr;
    dreq = 1; repeat (3) step();
    tag = "R12";
    base_we = 1; base_addr = 16'h5555; base_cnt = 16'd1; mask_set = 1; step();
    repeat (2) step();
    chk("R12", "addr unchanged", int'(caddr), int'(a0));
    chk("R12", "mask unchanged", int'(mask), 0);
    chk("R11", "hrq follows dreq", int'(hrq), 1);
    chk("R11", "dack follows hlda", int'(dack), 1);
    dreq = 0; repeat (4) step();

    tag = "R13";
    setup(2'b01, 0, 0, 0, 16'h4000, 16'd5);
    mask_set = 1; step();
    dreq = 1; repeat (5) step();
    chk("R13", "masked no request", int'(hrq), 0);
    mask_clr = 1; step();
    repeat (4) step();
    dreq = 0; repeat (8) step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule